// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flag Register

This block is the arithmetic and logic stage of a small eight-bit processor core, together with the register that holds the condition flags. Each accepted operation takes two byte operands and a four-bit operation code. The current carry comes from the block's own flag register. The block registers an eight-bit result and updates only the flags that belong to that operation. Every flag outside that subset keeps its value, so software can chain multi-byte arithmetic and test results without losing earlier conditions.

Byte operations finish one clock after they are accepted. The word add and word subtract act on a sixteen-bit register pair and a six-bit unsigned immediate. They return the low byte first and the high byte on the following clock. The block reports busy between the two beats and ignores any new request while busy. Flags are held in one eight-bit register. From bit 7 down to bit 0 it holds: interrupt enable, bit store, half carry, sign, overflow, negative, zero, carry. The two upper bits belong to the rest of the core. This block never writes them, so they stay at their reset value of zero.

Top module: `aluStatusTop`

## Requirements
- R1: After reset, `status`, `result`, `resValid` and `busy` are all zero. Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0, and bits 7 and 6 are never written.
- R2: ADD (code 0), ADC (code 1), SUB (code 2) and SBC (code 3) return A+B, A+B+C, A−B and A−B−C modulo 256. They write H, S, V, N, Z and C. C is the carry out of bit 7 (borrow for subtraction). H is the carry out of bit 3 (borrow into bit 4). V is signed two's-complement overflow.
- R3: AND (code 4), OR (code 5) and XOR (code 6) return the bitwise result. They write Z, N and S, and clear V. C and H keep their values.
- R4: INC (code 9) returns A+1 and DEC (code 10) returns A−1. Both write Z, N, V and S and keep C and H. V is set only when A is 0x7F for INC, or 0x80 for DEC.
- R5: COM (code 7) returns 0xFF−A. It sets C, clears V, writes Z, N and S, and keeps H.
- R6: NEG (code 8) returns 0x00−A and writes H, S, V, N, Z and C. C is set exactly when the result is nonzero, and V exactly when the result is 0x80.
- R7: SER (code 11) returns 0xFF and leaves every status bit unchanged.
- R8: Whenever N or V is written, S is written as N XOR V.
- R9: Word add (code 12) and word subtract (code 13) form the pair {opB, opA}, with opB as the high byte. They add or subtract the zero-extended `wordImm`. The low byte appears one clock after acceptance with `busy` high. The high byte appears on the next clock with `busy` low. At that second beat S, V, N, Z and C are written from the 16-bit result, and H is kept.
- R10: A byte operation accepted at a clock edge shows its result and flags right after that edge, with `resValid` high for exactly that cycle.
- R11: A request made while `busy` is high is ignored. Reserved codes 14 and 15 produce no result beat and change neither `result` nor `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Request strobe, sampled at the clock edge |
| opCode | input | 4 | Operation code (see requirements) |
| opA | input | DATA_W | First operand; low byte of the pair for word operations |
| opB | input | DATA_W | Second operand; high byte of the pair for word operations |
| wordImm | input | IMM_W | Unsigned immediate for word operations |
| result | output | DATA_W | Registered result byte |
| resValid | output | 1 | High for one cycle per result beat |
| busy | output | 1 | High between the two beats of a word operation |
| status | output | 8 | Flag register I,T,H,S,V,N,Z,C (bit 7 to bit 0) |

## Verification
The properties assume that `opValid` and `opCode` are known, two-state values on every clock edge after reset. They also assume that the environment may assert a request while `busy` is high, expecting that request to be dropped. The stimulus drives every input on the falling edge, so the values are stable at the sampling edge. Codes 14 and 15 appear only in directed tests. The bench keeps its own model of the flag register and compares all eight bits after each operation. Its carry-chain entries rely on the flags left by the preceding table entry.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W   = 4;
  localparam int SREG_W = 8;

  // Flag bit positions inside the status register
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  localparam logic [SREG_W-1:0] BIT_C = SREG_W'(1) << FLAG_C;
  localparam logic [SREG_W-1:0] BIT_Z = SREG_W'(1) << FLAG_Z;
  localparam logic [SREG_W-1:0] BIT_N = SREG_W'(1) << FLAG_N;
  localparam logic [SREG_W-1:0] BIT_V = SREG_W'(1) << FLAG_V;
  localparam logic [SREG_W-1:0] BIT_S = SREG_W'(1) << FLAG_S;
  localparam logic [SREG_W-1:0] BIT_H = SREG_W'(1) << FLAG_H;

  localparam logic [SREG_W-1:0] MASK_LOGIC = BIT_S | BIT_V | BIT_N | BIT_Z;
  localparam logic [SREG_W-1:0] MASK_CARRY = MASK_LOGIC | BIT_C;
  localparam logic [SREG_W-1:0] MASK_ARITH = MASK_CARRY | BIT_H;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_COM   = 4'd7,
    OP_NEG   = 4'd8,
    OP_INC   = 4'd9,
    OP_DEC   = 4'd10,
    OP_SER   = 4'd11,
    OP_WADD  = 4'd12,
    OP_WSUB  = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadByte;
    logic              wordLo;
    logic              wordHi;
    aluOp_e            op;
    logic [SREG_W-1:0] flagMask;
  } aluStrobe_t;

  function automatic logic [SREG_W-1:0] flagMaskFor(aluOp_e op);
    logic [SREG_W-1:0] m;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: m = MASK_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:  m = MASK_LOGIC;
      OP_COM, OP_WADD, OP_WSUB:               m = MASK_CARRY;
      default:                                m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe,
  output logic            busy
);

  aluOp_e opE;
  aluOp_e heldOp;
  logic   wordPhase;

  assign opE  = aluOp_e'(opCode);
  assign busy = wordPhase;

  always_comb begin
    strobe    = '0;
    strobe.op = opE;
    if (wordPhase) begin
      strobe.wordHi   = 1'b1;
      strobe.op       = heldOp;
      strobe.flagMask = flagMaskFor(heldOp);
    end else if (opValid) begin
      case (opE)
        OP_WADD, OP_WSUB: strobe.wordLo = 1'b1;
        OP_RSV14, OP_RSV15: ;
        default: begin
          strobe.loadByte = 1'b1;
          strobe.flagMask = flagMaskFor(opE);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPhase <= 1'b0;
      heldOp    <= OP_ADD;
    end else begin
      wordPhase <= strobe.wordLo;
      if (strobe.wordLo) heldOp <= opE;
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  wordImm,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic [SREG_W-1:0] status
);

  localparam int MSB = DATA_W - 1;
  localparam int NIB = 4;

  logic [DATA_W-1:0] hiHeld, loHeld;
  logic              chainCarry;

  logic              isSub, cIn;
  logic [DATA_W-1:0] x, y, yEff, res;
  logic [DATA_W:0]   sumExt;
  logic [NIB:0]      nibSum;
  logic              carryFlag, halfFlag, ovf, neg, zero;
  logic [SREG_W-1:0] flagNew;
  logic              anyBeat;

  always_comb begin
    isSub = 1'b0;
    x     = opA;
    y     = opB;
    cIn   = 1'b0;
    case (strobe.op)
      OP_ADC: cIn = status[FLAG_C];
      OP_SUB: begin isSub = 1'b1; cIn = 1'b1; end
      OP_SBC: begin isSub = 1'b1; cIn = ~status[FLAG_C]; end
      OP_NEG: begin isSub = 1'b1; x = '0; y = opA; cIn = 1'b1; end
      OP_INC: y = DATA_W'(1);
      OP_DEC: begin isSub = 1'b1; y = DATA_W'(1); cIn = 1'b1; end
      OP_WADD, OP_WSUB: begin
        isSub = (strobe.op == OP_WSUB);
        if (strobe.wordHi) begin
          x   = hiHeld;
          y   = '0;
          cIn = chainCarry;
        end else begin
          y   = DATA_W'(wordImm);
          cIn = isSub;
        end
      end
      default: ;
    endcase

    // Shared adder; subtraction as x + ~y + carry-in
    yEff      = isSub ? ~y : y;
    sumExt    = {1'b0, x} + {1'b0, yEff} + {{DATA_W{1'b0}}, cIn};
    nibSum    = {1'b0, x[NIB-1:0]} + {1'b0, yEff[NIB-1:0]} + {{NIB{1'b0}}, cIn};
    res       = sumExt[MSB:0];
    carryFlag = sumExt[DATA_W] ^ isSub;
    halfFlag  = nibSum[NIB] ^ isSub;
    ovf       = (x[MSB] == yEff[MSB]) && (res[MSB] != x[MSB]);

    case (strobe.op)
      OP_AND: begin res = opA & opB; ovf = 1'b0; end
      OP_OR:  begin res = opA | opB; ovf = 1'b0; end
      OP_XOR: begin res = opA ^ opB; ovf = 1'b0; end
      OP_COM: begin res = ~opA; ovf = 1'b0; carryFlag = 1'b1; end
      OP_SER: res = '1;
      default: ;
    endcase

    zero = (res == '0) && (!strobe.wordHi || (loHeld == '0));
    neg  = res[MSB];

    flagNew         = '0;
    flagNew[FLAG_C] = carryFlag;
    flagNew[FLAG_Z] = zero;
    flagNew[FLAG_N] = neg;
    flagNew[FLAG_V] = ovf;
    flagNew[FLAG_S] = neg ^ ovf;
    flagNew[FLAG_H] = halfFlag;
  end

  assign anyBeat = strobe.loadByte | strobe.wordLo | strobe.wordHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      resValid   <= 1'b0;
      status     <= '0;
      hiHeld     <= '0;
      loHeld     <= '0;
      chainCarry <= 1'b0;
    end else begin
      resValid <= anyBeat;
      if (anyBeat) result <= res;
      status <= (status & ~strobe.flagMask) | (flagNew & strobe.flagMask);
      if (strobe.wordLo) begin
        hiHeld     <= opB;
        loHeld     <= res;
        chainCarry <= sumExt[DATA_W];
      end
    end
  end

endmodule

// File: rtl/aluStatusTop.sv
module aluStatusTop
  import aluPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  wordImm,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              busy,
  output logic [SREG_W-1:0] status
);

  aluStrobe_t strobe;

  aluCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe),
    .busy    (busy)
  );

  aluDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .wordImm  (wordImm),
    .result   (result),
    .resValid (resValid),
    .status   (status)
  );

endmodule

// File: rtl/aluStatusChecker.sv
module aluStatusChecker
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              busy,
  input logic [SREG_W-1:0] status
);

  logic accepted;
  assign accepted = opValid && !busy;

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[FLAG_I:FLAG_T] == 2'b00); // R1

  AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rstN)
    status[FLAG_S] == (status[FLAG_N] ^ status[FLAG_V])); // R8

  AST_SET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opCode == OP_SER) |=> (status == $past(status)) && (result == '1)); // R7

  AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR ||
                  opCode == OP_INC || opCode == OP_DEC))
    |=> (status[FLAG_C] == $past(status[FLAG_C])) && (status[FLAG_H] == $past(status[FLAG_H]))); // R3

  AST_COM_SETS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opCode == OP_COM) |=> status[FLAG_C] && !status[FLAG_V]); // R5

  AST_WORD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (opCode == OP_WADD || opCode == OP_WSUB)) |=> busy && resValid); // R9

  AST_WORD_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy && resValid); // R9

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (opCode == OP_RSV14 || opCode == OP_RSV15))
    |=> !resValid && $stable(status) && $stable(result)); // R11

endmodule

bind aluStatusTop aluStatusChecker #(.DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .result   (result),
  .resValid (resValid),
  .busy     (busy),
  .status   (status)
);

// File: tb/test_aluStatusTop.sv
module test_aluStatusTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic [5:0] wordImm = '0;
  logic [7:0] result;
  logic       resValid, busy;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] expFlags = '0;

  always #5 clk = ~clk;

  aluStatusTop i_aluStatusTop (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .wordImm(wordImm),
    .result(result), .resValid(resValid), .busy(busy), .status(status)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {op, a, b, imm, expected final result byte}
  localparam logic [35:0] VEC [17] = '{
    {4'd0,  8'h7F, 8'h01, 8'h00, 8'h80},
    {4'd0,  8'hFF, 8'h01, 8'h00, 8'h00},
    {4'd1,  8'h10, 8'h20, 8'h00, 8'h31},
    {4'd2,  8'h00, 8'h01, 8'h00, 8'hFF},
    {4'd3,  8'h10, 8'h05, 8'h00, 8'h0A},
    {4'd4,  8'hF0, 8'h3C, 8'h00, 8'h30},
    {4'd5,  8'hF0, 8'h0F, 8'h00, 8'hFF},
    {4'd6,  8'hAA, 8'hAA, 8'h00, 8'h00},
    {4'd7,  8'h00, 8'h00, 8'h00, 8'hFF},
    {4'd8,  8'h80, 8'h00, 8'h00, 8'h80},
    {4'd8,  8'h00, 8'h00, 8'h00, 8'h00},
    {4'd9,  8'h7F, 8'h00, 8'h00, 8'h80},
    {4'd10, 8'h80, 8'h00, 8'h00, 8'h7F},
    {4'd11, 8'h12, 8'h34, 8'h00, 8'hFF},
    {4'd12, 8'hFF, 8'hFF, 8'h01, 8'h00},
    {4'd13, 8'h00, 8'h80, 8'h01, 8'h7F},
    {4'd12, 8'hF0, 8'h7F, 8'h3F, 8'h80}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string reqFor(input int op);
    case (op)
      0, 1, 2, 3: return "R2";
      4, 5, 6:    return "R3";
      7:          return "R5";
      8:          return "R6";
      9, 10:      return "R4";
      11:         return "R7";
      12, 13:     return "R9";
      default:    return "R11";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Reference model: expected bytes and flag register update
  task automatic modelStep(input int op, input int a, input int b, input int imm,
                           output int lo, output int hi);
    int r, x, y, bi, ci, w, ws, sr;
    bit fc, fz, fn, fv, fh;
    logic [7:0] m, newF;
    fc = expFlags[0]; fh = expFlags[5]; fv = 1'b0; m = 8'h00; hi = 0; r = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(expFlags[0]) : 0;
        r = a + b + ci; fc = (r > 255);
        fh = ((a % 16) + (b % 16) + ci) > 15;
        sr = sgn(a) + sgn(b) + ci; fv = (sr > 127) || (sr < -128);
        m = 8'h3F;
      end
      2, 3, 8: begin
        x = (op == 8) ? 0 : a; y = (op == 8) ? a : b;
        bi = (op == 3) ? int'(expFlags[0]) : 0;
        r = x - y - bi; fc = (r < 0);
        fh = ((x % 16) - (y % 16) - bi) < 0;
        sr = sgn(x) - sgn(y) - bi; fv = (sr > 127) || (sr < -128);
        m = 8'h3F;
      end
      4: begin r = a & b; m = 8'h1E; end
      5: begin r = a | b; m = 8'h1E; end
      6: begin r = a ^ b; m = 8'h1E; end
      7: begin r = 255 - a; fc = 1'b1; m = 8'h1F; end
      9: begin r = a + 1; fv = (a == 127); m = 8'h1E; end
      10: begin r = a - 1; fv = (a == 128); m = 8'h1E; end
      11: r = 255;
      default: ;
    endcase
    if (op == 12 || op == 13) begin
      w = b * 256 + a;
      ws = (b >= 128) ? w - 65536 : w;
      if (op == 12) begin r = w + imm; sr = ws + imm; fc = (r > 65535); end
      else          begin r = w - imm; sr = ws - imm; fc = (r < 0); end
      fv = (sr > 32767) || (sr < -32768);
      r = r & 65535;
      lo = r & 255; hi = (r >> 8) & 255;
      fz = (r == 0); fn = (r >= 32768);
      m = 8'h1F;
    end else begin
      r = r & 255;
      lo = r;
      fz = (r == 0); fn = (r >= 128);
    end
    newF = {2'b00, fh, fn ^ fv, fv, fn, fz, fc};
    expFlags = (expFlags & ~m) | (newF & m);
  endtask

  task automatic runOp(input int op, input int a, input int b, input int imm, output int finalRes);
    int lo, hi;
    string tag;
    tag = reqFor(op);
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(op); opA = 8'(a); opB = 8'(b); wordImm = 6'(imm);
    modelStep(op, a, b, imm, lo, hi);
    @(negedge clk);
    opValid = 1'b0;
    if (op == 12 || op == 13) begin
      check(result == 8'(lo) && busy && resValid, {tag, " word low beat"}, result, lo);
      @(negedge clk);
      check(result == 8'(hi) && !busy && resValid, {tag, " word high beat"}, result, hi);
      finalRes = hi;
    end else begin
      check(result == 8'(lo), {tag, " result"}, result, lo);
      check(resValid == 1'b1, "R10 result valid", resValid, 1);
      finalRes = lo;
    end
    check(status == expFlags, {tag, "/R8 flags"}, status, expFlags);
  endtask

  int corners [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};

  initial begin
    int fr;
    logic [7:0] keepRes;
    // Reset state
    repeat (3) @(negedge clk);
    check(status == 8'h00 && result == 8'h00, "R1 reset status/result", status, 0);
    check(!resValid && !busy, "R1 reset valid/busy", {resValid, busy}, 0);
    rstN = 1'b1;

    // Vector table
    foreach (VEC[i]) begin
      runOp(int'(VEC[i][35:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]),
            int'(VEC[i][13:8]), fr);
      check(fr == int'(VEC[i][7:0]), {reqFor(int'(VEC[i][35:32])), " table entry"}, fr, VEC[i][7:0]);
    end

    // Corner operands for every operation code
    for (int op = 0; op < 14; op++)
      foreach (corners[i])
        foreach (corners[j])
          runOp(op, corners[i], corners[j], corners[j] & 63, fr);

    // Random operands
    for (int k = 0; k < 300; k++)
      runOp(int'($urandom_range(0, 13)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 63)), fr);

    // R11: request during busy is dropped
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd12; opA = 8'h34; opB = 8'h12; wordImm = 6'd5;
    begin
      int lo, hi;
      modelStep(12, 'h34, 'h12, 5, lo, hi);
      @(negedge clk);
      check(busy && result == 8'(lo), "R9 busy low beat", result, lo);
      opCode = 4'd11;
      @(negedge clk);
      opValid = 1'b0;
      check(result == 8'(hi), "R11 busy request ignored result", result, hi);
      check(status == expFlags, "R11 busy request flags", status, expFlags);
      @(negedge clk);
      check(!resValid && result == 8'(hi), "R11 no beat for dropped request", result, hi);
    end

    // R11: reserved codes
    for (int op = 14; op < 16; op++) begin
      keepRes = result;
      @(negedge clk);
      opValid = 1'b1; opCode = 4'(op); opA = 8'h55; opB = 8'hAA;
      @(negedge clk);
      opValid = 1'b0;
      check(!resValid, "R11 reserved no beat", resValid, 0);
      check(status == expFlags && result == keepRes, "R11 reserved no change", status, expFlags);
    end

    // Mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(status == 8'h00 && result == 8'h00 && !busy, "R1 mid-run reset", status, 0);
    rstN = 1'b1;
    expFlags = '0;
    runOp(2, 0, 1, 0, fr);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule